// File: doc/BRIEF.md
# Microcode Word Fetch Sequencer

This block assembles a 32-bit microcode control word from a memory that is only one byte wide. It does this with four byte reads. One fast base clock drives a free-running tick counter. The counter's top bit is the master phase, a square wave with equal high and low halves. The counter's low bits time the memory reads. Because both timings come from the same counter, they keep a fixed relationship and cannot slip against each other.

While the master phase is low, the block issues four read strobes. Each strobe carries a 13-bit address built from three parts: the current opcode, the current micro-step and a byte index that counts 0 to 3. Each returned byte is placed in its own slice of the word. The full word then appears on the output in one update, on the tick where the master phase goes high. The micro-step advances each time the master phase falls. Everything runs on the base clock and uses enables; no other clock is generated.

The memory is expected to be a synchronous read port. It returns the addressed byte on `mem_data` one base tick after the tick in which `mem_rd` is high. The opcode must be held stable for the whole low half of the master phase.

Top module: `ucode_word_fetch`

## Requirements
- R1: `master_phase` repeats 8 base ticks low then 8 base ticks high. It starts with its low half on the first tick after reset is released.
- R2: Exactly four read strobes (`mem_rd` high for one tick) occur in every low half, on the 1st, 3rd, 5th and 7th low ticks. No strobe occurs while `master_phase` is high.
- R3: During a strobe, `mem_addr[7:0]` is the opcode, `mem_addr[10:8]` is the current micro-step, and `mem_addr[12:11]` is the byte index. The byte index is 0, 1, 2, 3 for the four strobes of a low half, in that order.
- R4: The byte returned for byte index k lands in `ctrl_word[8k+7:8k]`. Byte index 0 fills bits [7:0] and byte index 3 fills bits [31:24].
- R5: `ctrl_word` changes only on the tick where `master_phase` goes from low to high. On that tick it takes the complete word of the low half that just ended. At all other times it holds.
- R6: `ustep` increments by one on each tick where `master_phase` goes from high to low, and wraps from 7 to 0. It is constant between such ticks.
- R7: While synchronous reset `rst` is high, `ctrl_word`, `ustep` and `master_phase` are 0 and `mem_rd` is 0. This holds even when reset arrives partway through a word fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock; all registers use its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 8 | Current instruction opcode, held stable during the low half |
| master_phase | output | 1 | 50% duty master timing phase |
| ustep | output | 3 | Current micro-step |
| mem_rd | output | 1 | Read strobe to the byte-wide microcode memory |
| mem_addr | output | 13 | Memory address {byte index, micro-step, opcode} |
| mem_data | input | 8 | Byte returned by the memory one tick after a strobe |
| ctrl_word | output | 32 | Assembled control word |

## Verification
The hardest case to reach from the ports is a reset that lands in the middle of a low half. At that point some byte slices are already staged and others are not. The output must still clear at once, and the next word must be built only from fresh reads. To create this case, the stimulus waits for a falling edge of the master phase, lets three base ticks pass so that two bytes are already in flight, and then asserts reset. The bench then restarts its expected sequence from micro-step 0. Each run also lasts more than eight master periods, so the micro-step wrap from 7 to 0 is observed both in the addresses and on `ustep`.

// File: rtl/ucode_word_fetch.sv
module ucode_word_fetch #(
  parameter int OP_W   = 8,
  parameter int STEP_W = 3,
  parameter int IDX_W  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [OP_W-1:0]                 opcode,
  output logic                            master_phase,
  output logic [STEP_W-1:0]               ustep,
  output logic                            mem_rd,
  output logic [IDX_W+STEP_W+OP_W-1:0]    mem_addr,
  input  logic [BYTE_W-1:0]               mem_data,
  output logic [(BYTE_W<<IDX_W)-1:0]      ctrl_word
);

  localparam int NBYTES = 1 << IDX_W;
  localparam int WORD_W = BYTE_W * NBYTES;
  localparam int CNT_W  = IDX_W + 2;
  localparam logic [CNT_W-1:0] LAST_LOW = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] LAST     = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  tick;
  logic [IDX_W-1:0]  idx;
  logic              capture;
  logic [WORD_W-1:0] word_nxt;
  logic [BYTE_W-1:0] stage [NBYTES-1];

  assign master_phase = tick[CNT_W-1];
  assign idx          = tick[CNT_W-2:1];
  assign mem_rd       = !rst && !master_phase && !tick[0];
  assign mem_addr     = {idx, ustep, opcode};
  assign capture      = !master_phase && tick[0];

  always_ff @(posedge clk) begin
    if (rst) tick <= '0;
    else     tick <= tick + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)               ustep <= '0;
    else if (tick == LAST) ustep <= ustep + 1'b1;
  end

  for (genvar k = 0; k < NBYTES; k++) begin : g_slice
    if (k == NBYTES - 1) begin : g_last
      assign word_nxt[k*BYTE_W +: BYTE_W] = mem_data;
    end else begin : g_staged
      always_ff @(posedge clk) begin
        if (rst)                             stage[k] <= '0;
        else if (capture && idx == IDX_W'(k)) stage[k] <= mem_data;
      end
      assign word_nxt[k*BYTE_W +: BYTE_W] = stage[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   ctrl_word <= '0;
    else if (tick == LAST_LOW) ctrl_word <= word_nxt;
  end

  logic [IDX_W:0] rd_seen;
  always_ff @(posedge clk) begin
    if (rst || tick == LAST) rd_seen <= '0;
    else if (mem_rd)         rd_seen <= rd_seen + 1'b1;
  end

  AST_MASTER_RISE: assert property (@(posedge clk) disable iff (rst)
    (tick == LAST_LOW) |=> master_phase); // R1
  AST_FOUR_READS: assert property (@(posedge clk) disable iff (rst)
    (tick == LAST_LOW) |-> (rd_seen == (IDX_W+1)'(NBYTES))); // R2
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tick != LAST_LOW) |=> $stable(ctrl_word)); // R5
  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tick != LAST) |=> $stable(ustep)); // R6
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick == LAST && ustep == {STEP_W{1'b1}}) |=> (ustep == '0)); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (ctrl_word == '0 && ustep == '0 && !master_phase)); // R7

endmodule

// File: tb/tb_ucode_word_fetch.sv
module tb_ucode_word_fetch;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic [7:0]  opcode = 8'h00;
  logic        master;
  logic [2:0]  ustep;
  logic        mem_rd;
  logic [12:0] mem_addr;
  logic [7:0]  mem_data;
  logic [31:0] ctrl_word;

  always #(CLK_P/2) clk = ~clk;

  ucode_word_fetch dut (
    .clk(clk), .rst(rst), .opcode(opcode), .master_phase(master),
    .ustep(ustep), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_data(mem_data), .ctrl_word(ctrl_word)
  );

  function automatic logic [7:0] mem_f(input logic [12:0] a);
    return (a[7:0] + 8'h3B * {6'd0, a[12:11]}) ^ {a[10:8], 5'b10101};
  endfunction

  function automatic logic [31:0] exp_word(input logic [2:0] st, input logic [7:0] op);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) w[8*k +: 8] = mem_f({k[1:0], st, op});
    return w;
  endfunction

  always @(posedge clk) if (mem_rd) mem_data <= mem_f(mem_addr);

  typedef struct { logic [31:0] w; logic [2:0] st; logic [7:0] op; } item_t;
  item_t q[$];
  item_t it;

  int checks = 0, fails = 0;
  bit mon_en = 0;
  logic prev_m;
  int run_len, reads;
  logic [31:0] last_word;
  logic [12:0] exp_a;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (mon_en) begin
    if (master && !prev_m) begin
      chk(run_len == 8, "R1 low half length", run_len, 8);
      chk(reads == 4, "R2 reads per low half", reads, 4);
      if (q.size() == 0) chk(0, "R4 no expected word queued", ctrl_word, 0);
      else begin
        it = q.pop_front();
        chk(ctrl_word == it.w, "R4 assembled word", ctrl_word, it.w);
        chk(ustep == it.st, "R6 step of finished half", {29'd0, ustep}, {29'd0, it.st});
      end
      last_word = ctrl_word; run_len = 1; reads = 0;
    end else if (!master && prev_m) begin
      chk(run_len == 8, "R1 high half length", run_len, 8);
      chk(ctrl_word == last_word, "R5 word held at fall", ctrl_word, last_word);
      run_len = 1;
    end else begin
      run_len++;
      chk(ctrl_word == last_word, "R5 word held", ctrl_word, last_word);
    end
    if (mem_rd) begin
      chk(!master, "R2 strobe in high half", {31'd0, master}, 0);
      chk((run_len % 2) == 1, "R2 strobe on odd low tick", run_len, 1);
      if (q.size() != 0) begin
        exp_a = {reads[1:0], q[0].st, q[0].op};
        chk(mem_addr == exp_a, "R3 address fields", {19'd0, mem_addr}, {19'd0, exp_a});
      end
      reads++;
    end
    prev_m = master;
  end

  task automatic check_reset();
    chk(ctrl_word == 0, "R7 word cleared", ctrl_word, 0);
    chk(ustep == 0, "R7 step cleared", {29'd0, ustep}, 0);
    chk(!master, "R7 master low", {31'd0, master}, 0);
    chk(!mem_rd, "R7 no strobe in reset", {31'd0, mem_rd}, 0);
  endtask

  task automatic run(input int n, input logic [7:0] seed, input logic [7:0] inc);
    logic [2:0] st = 0;
    logic [7:0] op = seed;
    opcode = op;
    q.push_back('{exp_word(st, op), st, op});
    @(posedge clk); #1;
    rst = 0; prev_m = 0; run_len = 0; reads = 0; last_word = 0; mon_en = 1;
    repeat (n) begin
      @(posedge master); #1;
      st = st + 3'd1;
      op = op + inc;
      opcode = op;
      q.push_back('{exp_word(st, op), st, op});
    end
  endtask

  task automatic reset_mid();
    @(negedge master);
    repeat (3) @(posedge clk);
    #1; rst = 1; mon_en = 0; q.delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset();
    run(20, 8'h00, 8'd37);
    reset_mid();
    run(12, 8'hFF, 8'hB5);
    reset_mid();
    run(10, 8'hA5, 8'd0);
    @(posedge master); @(negedge clk); @(negedge clk);
    mon_en = 0;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule